// File: doc/BRIEF.md
# Cache-Line Candidate Lockset Checker

This block tracks, for every entry of a small directly indexed table of cache lines, a 2-bit coherence-style line state and a 16-bit candidate lockset vector. The vector is a Bloom-style filter of the locks that have protected every access to the line so far. A line brought in through the fill port starts exclusive with an all-ones vector, because every lock is still a candidate. Each access through the access port narrows the vector by ANDing in the accessing thread's own 16-bit lockset filter.

The vector is split into four 4-bit hash parts. The candidate set counts as empty as soon as any one part has no bit left set. The access that first causes this raises a one-cycle race pulse that carries the line index. When a line that is in the shared state has its vector changed by an access, the block raises a broadcast request carrying the line index and the new vector, so that the other copies can be brought up to date. Updates arriving from peers overwrite the named line's vector. A barrier-exit pulse gives every line a fresh all-ones vector. A combinational probe port returns the state and vector of any line.

Top module: `lockset_line_checker`

## Requirements
- R1: After reset every line reads back through the probe port with state 2'b00 (invalid) and vector 16'hFFFF, and both race_pulse and bcast_req are low.
- R2: A fill sets the named line to state 2'b01 (exclusive) and vector 16'hFFFF, and records fill_core as the line's owner. A fill wins over an access to the same line in the same cycle.
- R3: An access to a valid line replaces its vector with the bitwise AND of the vector and acc_lockset, visible through the probe port after the clock edge that takes the access.
- R4: State encoding is 2'b00 invalid, 2'b01 exclusive, 2'b10 shared, 2'b11 modified. A write (acc_write=1) moves the line to modified. A read by a core other than the recorded owner moves it to shared. A read by the owner leaves the state unchanged.
- R5: Bits [3:0], [7:4], [11:8] and [15:12] form the four hash parts. race_pulse rises for exactly one cycle, one clock after an access, with race_idx set to that access's line, only when the vector had no all-zero part before the access and has one after it.
- R6: When an access changes the vector of a line whose state was shared (2'b10) before the access, bcast_req is high for one cycle, one clock later, with bcast_idx set to the line and bcast_vec set to the new vector. No request is raised when the vector is unchanged or the line was not shared.
- R7: A barrier_exit pulse sets every line's vector to 16'hFFFF and leaves the states unchanged. An access in the same cycle is dropped entirely: no state change, no race and no broadcast request.
- R8: An access to an invalid line is ignored: the state and vector stay the same, and no race or broadcast request is raised.
- R9: A peer update (peer_valid) overwrites the vector of the line named by peer_idx with peer_vec. It raises no race pulse.
- R10: probe_state and probe_vec show the current contents of the line selected by probe_idx, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fill a line from memory |
| fill_idx | input | 4 | Line being filled |
| fill_core | input | 2 | Core that performs the fill |
| acc_valid | input | 1 | An access is presented |
| acc_idx | input | 4 | Line accessed |
| acc_lockset | input | 16 | Lockset filter of the accessing thread |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_core | input | 2 | Core that performs the access |
| barrier_exit | input | 1 | Pulse on barrier exit |
| peer_valid | input | 1 | Vector update arriving from a peer |
| peer_idx | input | 4 | Line named by the peer update |
| peer_vec | input | 16 | New vector from the peer |
| probe_idx | input | 4 | Line to read back |
| probe_state | output | 2 | State of the probed line |
| probe_vec | output | 16 | Vector of the probed line |
| race_pulse | output | 1 | One-cycle race report |
| race_idx | output | 4 | Line of the reported race |
| bcast_req | output | 1 | One-cycle broadcast request |
| bcast_idx | output | 4 | Line to broadcast |
| bcast_vec | output | 16 | New vector to broadcast |

## Verification
The hardest condition to reach is a vector change on a line that is already shared. It needs a fill by one core, then a narrowing read by a second core to reach shared, then a further narrowing access. That sequence is laid out in the stimulus table. The table then keeps narrowing the same line until a part empties, and applies more accesses to show that the race is not reported a second time. It also moves the line back through modified to shared without a request. Directed steps then combine a barrier with a same-cycle access, and empty a line through a peer update, so that a later access to that line must stay silent.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  parameter int unsigned LSC_NUM_LINES = 16;
  parameter int unsigned LSC_VEC_W     = 16;
  parameter int unsigned LSC_PART_W    = 4;
  parameter int unsigned LSC_CORE_W    = 2;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_EXC = 2'b01,
    LS_SHR = 2'b10,
    LS_MOD = 2'b11
  } line_st_e;
endpackage

// File: rtl/lsc_line_table.sv
module lsc_line_table
  import lsc_pkg::*;
#(
  parameter int unsigned NUM_LINES = LSC_NUM_LINES,
  parameter int unsigned VEC_W     = LSC_VEC_W,
  parameter int unsigned CORE_W    = LSC_CORE_W,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [CORE_W-1:0] fill_core,
  input  logic              barrier,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [1:0]        upd_state,
  input  logic [VEC_W-1:0]  upd_vec,
  input  logic              peer_valid,
  input  logic [IDX_W-1:0]  peer_idx,
  input  logic [VEC_W-1:0]  peer_vec,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [1:0]        rd_state,
  output logic [VEC_W-1:0]  rd_vec,
  output logic [CORE_W-1:0] rd_owner,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic [1:0]        probe_state,
  output logic [VEC_W-1:0]  probe_vec
);

  logic [NUM_LINES-1:0][1:0]        st_q;
  logic [NUM_LINES-1:0][VEC_W-1:0]  vec_q;
  logic [NUM_LINES-1:0][CORE_W-1:0] own_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic              fill_hit, upd_hit, peer_hit, line_en;
    logic [1:0]        st_d;
    logic [VEC_W-1:0]  vec_d;
    logic [CORE_W-1:0] own_d;

    assign fill_hit = fill_valid && (fill_idx == IDX_W'(l));
    assign upd_hit  = upd_valid  && (upd_idx  == IDX_W'(l));
    assign peer_hit = peer_valid && (peer_idx == IDX_W'(l));
    assign line_en  = fill_hit || barrier || upd_hit || peer_hit;

    always_comb begin
      st_d  = st_q[l];
      vec_d = vec_q[l];
      own_d = own_q[l];
      if (fill_hit) begin
        st_d  = LS_EXC;
        vec_d = '1;
        own_d = fill_core;
      end else if (barrier) begin
        vec_d = '1;
      end else if (upd_hit) begin
        st_d  = upd_state;
        vec_d = upd_vec;
      end else if (peer_hit) begin
        vec_d = peer_vec;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[l]  <= LS_INV;
        vec_q[l] <= '1;
        own_q[l] <= '0;
      end else if (line_en) begin
        st_q[l]  <= st_d;
        vec_q[l] <= vec_d;
        own_q[l] <= own_d;
      end
    end

    AST_FILL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      fill_hit |=> (st_q[l] == LS_EXC) && (&vec_q[l])); // R2

    AST_AND_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_hit && !fill_hit && !barrier) |=> ((vec_q[l] & ~$past(vec_q[l])) == '0)); // R3

    AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!fill_hit && st_q[l] == LS_INV) |=> (st_q[l] == LS_INV)); // R8
  end

  AST_BARRIER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    barrier |=> (&vec_q)); // R7

  assign rd_state    = st_q[rd_idx];
  assign rd_vec      = vec_q[rd_idx];
  assign rd_owner    = own_q[rd_idx];
  assign probe_state = st_q[probe_idx];
  assign probe_vec   = vec_q[probe_idx];

endmodule

// File: rtl/lsc_access_unit.sv
module lsc_access_unit
  import lsc_pkg::*;
#(
  parameter int unsigned VEC_W  = LSC_VEC_W,
  parameter int unsigned PART_W = LSC_PART_W,
  parameter int unsigned CORE_W = LSC_CORE_W,
  localparam int unsigned NUM_PARTS = VEC_W / PART_W
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [CORE_W-1:0] acc_core,
  input  logic [VEC_W-1:0]  acc_lockset,
  input  logic              barrier,
  input  logic              fill_clash,
  input  logic [1:0]        cur_state,
  input  logic [VEC_W-1:0]  cur_vec,
  input  logic [CORE_W-1:0] cur_owner,
  output logic              upd_valid,
  output logic [1:0]        upd_state,
  output logic [VEC_W-1:0]  upd_vec,
  output logic              race_hit,
  output logic              bcast_hit
);

  logic [NUM_PARTS-1:0] old_zero;
  logic [NUM_PARTS-1:0] new_zero;
  logic                 live;

  assign upd_vec = cur_vec & acc_lockset;

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    assign old_zero[p] = ~|cur_vec[p*PART_W +: PART_W];
    assign new_zero[p] = ~|upd_vec[p*PART_W +: PART_W];
  end

  assign live      = acc_valid && !barrier && !fill_clash && (cur_state != LS_INV);
  assign upd_valid = live;
  assign race_hit  = live && !(|old_zero) && (|new_zero);
  assign bcast_hit = live && (cur_state == LS_SHR) && (upd_vec != cur_vec);

  always_comb begin
    upd_state = cur_state;
    if (acc_write) begin
      upd_state = LS_MOD;
    end else if (acc_core != cur_owner) begin
      upd_state = LS_SHR;
    end
  end

endmodule

// File: rtl/lsc_event_reg.sv
module lsc_event_reg #(
  parameter int unsigned VEC_W = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             race_hit,
  input  logic             bcast_hit,
  input  logic [IDX_W-1:0] line_idx,
  input  logic [VEC_W-1:0] new_vec,
  output logic             race_pulse,
  output logic [IDX_W-1:0] race_idx,
  output logic             bcast_req,
  output logic [IDX_W-1:0] bcast_idx,
  output logic [VEC_W-1:0] bcast_vec
);

  logic             race_d, bcast_d;
  logic [IDX_W-1:0] race_idx_d, bcast_idx_d;
  logic [VEC_W-1:0] bcast_vec_d;

  always_comb begin
    race_d      = race_hit;
    bcast_d     = bcast_hit;
    race_idx_d  = line_idx;
    bcast_idx_d = line_idx;
    bcast_vec_d = new_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      race_pulse <= 1'b0;
      bcast_req  <= 1'b0;
    end else begin
      race_pulse <= race_d;
      bcast_req  <= bcast_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      race_idx <= '0;
    end else if (race_hit) begin
      race_idx <= race_idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcast_idx <= '0;
      bcast_vec <= '0;
    end else if (bcast_hit) begin
      bcast_idx <= bcast_idx_d;
      bcast_vec <= bcast_vec_d;
    end
  end

endmodule

// File: rtl/lockset_line_checker.sv
module lockset_line_checker
  import lsc_pkg::*;
#(
  parameter int unsigned NUM_LINES = LSC_NUM_LINES,
  parameter int unsigned VEC_W     = LSC_VEC_W,
  parameter int unsigned PART_W    = LSC_PART_W,
  parameter int unsigned CORE_W    = LSC_CORE_W,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [CORE_W-1:0] fill_core,
  input  logic              acc_valid,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [VEC_W-1:0]  acc_lockset,
  input  logic              acc_write,
  input  logic [CORE_W-1:0] acc_core,
  input  logic              barrier_exit,
  input  logic              peer_valid,
  input  logic [IDX_W-1:0]  peer_idx,
  input  logic [VEC_W-1:0]  peer_vec,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic [1:0]        probe_state,
  output logic [VEC_W-1:0]  probe_vec,
  output logic              race_pulse,
  output logic [IDX_W-1:0]  race_idx,
  output logic              bcast_req,
  output logic [IDX_W-1:0]  bcast_idx,
  output logic [VEC_W-1:0]  bcast_vec
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [1:0]        cur_state;
  logic [VEC_W-1:0]  cur_vec;
  logic [CORE_W-1:0] cur_owner;
  logic              fill_clash;
  logic              upd_valid;
  logic [1:0]        upd_state;
  logic [VEC_W-1:0]  upd_vec;
  logic              race_hit;
  logic              bcast_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n  = rst_sync_q[1];

  assign fill_clash = fill_valid && (fill_idx == acc_idx);

  lsc_line_table #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .CORE_W    (CORE_W)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fill_valid  (fill_valid),
    .fill_idx    (fill_idx),
    .fill_core   (fill_core),
    .barrier     (barrier_exit),
    .upd_valid   (upd_valid),
    .upd_idx     (acc_idx),
    .upd_state   (upd_state),
    .upd_vec     (upd_vec),
    .peer_valid  (peer_valid),
    .peer_idx    (peer_idx),
    .peer_vec    (peer_vec),
    .rd_idx      (acc_idx),
    .rd_state    (cur_state),
    .rd_vec      (cur_vec),
    .rd_owner    (cur_owner),
    .probe_idx   (probe_idx),
    .probe_state (probe_state),
    .probe_vec   (probe_vec)
  );

  lsc_access_unit #(
    .VEC_W  (VEC_W),
    .PART_W (PART_W),
    .CORE_W (CORE_W)
  ) u_access (
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_core    (acc_core),
    .acc_lockset (acc_lockset),
    .barrier     (barrier_exit),
    .fill_clash  (fill_clash),
    .cur_state   (cur_state),
    .cur_vec     (cur_vec),
    .cur_owner   (cur_owner),
    .upd_valid   (upd_valid),
    .upd_state   (upd_state),
    .upd_vec     (upd_vec),
    .race_hit    (race_hit),
    .bcast_hit   (bcast_hit)
  );

  lsc_event_reg #(
    .VEC_W (VEC_W),
    .IDX_W (IDX_W)
  ) u_events (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .race_hit   (race_hit),
    .bcast_hit  (bcast_hit),
    .line_idx   (acc_idx),
    .new_vec    (upd_vec),
    .race_pulse (race_pulse),
    .race_idx   (race_idx),
    .bcast_req  (bcast_req),
    .bcast_idx  (bcast_idx),
    .bcast_vec  (bcast_vec)
  );

  AST_RACE_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_int_n)
    race_pulse |-> $past(acc_valid && !barrier_exit) && (race_idx == $past(acc_idx))); // R5

  AST_BCAST_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_int_n)
    bcast_req |-> $past(acc_valid && !barrier_exit) && (bcast_idx == $past(acc_idx))); // R6

endmodule

// File: tb/lockset_line_checker_bench.sv
module lockset_line_checker_bench;

  typedef struct packed {
    logic        is_acc;
    logic [3:0]  idx;
    logic [15:0] ls;
    logic        wr;
    logic [1:0]  core;
    logic [1:0]  e_st;
    logic [15:0] e_vec;
    logic        e_race;
    logic        e_bc;
    logic [15:0] e_bvec;
  } step_t;

  localparam int NSTEP = 10;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 4'd5, 16'h0000, 1'b0, 2'd0, 2'b01, 16'hFFFF, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 4'd5, 16'h3366, 1'b0, 2'd1, 2'b10, 16'h3366, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 4'd5, 16'h1324, 1'b0, 2'd0, 2'b10, 16'h1324, 1'b0, 1'b1, 16'h1324},
    '{1'b1, 4'd5, 16'h1300, 1'b1, 2'd0, 2'b11, 16'h1300, 1'b1, 1'b1, 16'h1300},
    '{1'b1, 4'd5, 16'hFFFF, 1'b1, 2'd0, 2'b11, 16'h1300, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 4'd5, 16'h0000, 1'b0, 2'd1, 2'b10, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 4'd5, 16'h0000, 1'b0, 2'd1, 2'b01, 16'hFFFF, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 4'd9, 16'h0000, 1'b0, 2'd0, 2'b00, 16'hFFFF, 1'b0, 1'b0, 16'h0000},
    '{1'b1, 4'd5, 16'hFFF0, 1'b0, 2'd1, 2'b01, 16'hFFF0, 1'b1, 1'b0, 16'h0000},
    '{1'b1, 4'd5, 16'hFFFF, 1'b0, 2'd0, 2'b10, 16'hFFF0, 1'b0, 1'b0, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fill_valid, acc_valid, acc_write, barrier_exit, peer_valid;
  logic [3:0]  fill_idx, acc_idx, peer_idx, probe_idx;
  logic [1:0]  fill_core, acc_core;
  logic [15:0] acc_lockset, peer_vec;
  logic [1:0]  probe_state;
  logic [15:0] probe_vec, bcast_vec;
  logic        race_pulse, bcast_req;
  logic [3:0]  race_idx, bcast_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  lockset_line_checker u_lockset_line_checker (
    .clk (clk), .rst_n (rst_n),
    .fill_valid (fill_valid), .fill_idx (fill_idx), .fill_core (fill_core),
    .acc_valid (acc_valid), .acc_idx (acc_idx), .acc_lockset (acc_lockset),
    .acc_write (acc_write), .acc_core (acc_core),
    .barrier_exit (barrier_exit),
    .peer_valid (peer_valid), .peer_idx (peer_idx), .peer_vec (peer_vec),
    .probe_idx (probe_idx), .probe_state (probe_state), .probe_vec (probe_vec),
    .race_pulse (race_pulse), .race_idx (race_idx),
    .bcast_req (bcast_req), .bcast_idx (bcast_idx), .bcast_vec (bcast_vec)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fill_valid = 0; acc_valid = 0; acc_write = 0; barrier_exit = 0; peer_valid = 0;
    fill_idx = 0; acc_idx = 0; peer_idx = 0; fill_core = 0; acc_core = 0;
    acc_lockset = 0; peer_vec = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check_line(input logic [3:0] idx, input logic [1:0] st,
                            input logic [15:0] v, input string tag);
    probe_idx = idx; #1;
    check(probe_state == st, tag, 32'(probe_state), 32'(st));
    check(probe_vec == v, tag, 32'(probe_vec), 32'(v));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    probe_idx = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1 reset contents, R10 probe
    check_line(4'd0, 2'b00, 16'hFFFF, "R1 reset line 0");
    check_line(4'd15, 2'b00, 16'hFFFF, "R1_R10 reset line 15");
    check(race_pulse == 0, "R1 race low", 32'(race_pulse), 0);
    check(bcast_req == 0, "R1 bcast low", 32'(bcast_req), 0);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      idle_inputs();
      if (STEPS[i].is_acc) begin
        acc_valid = 1; acc_idx = STEPS[i].idx; acc_lockset = STEPS[i].ls;
        acc_write = STEPS[i].wr; acc_core = STEPS[i].core;
      end else begin
        fill_valid = 1; fill_idx = STEPS[i].idx; fill_core = STEPS[i].core;
      end
      tick();
      check_line(STEPS[i].idx, STEPS[i].e_st, STEPS[i].e_vec, "R2_R3_R4_R8 step line");
      check(race_pulse == STEPS[i].e_race, "R5 step race", 32'(race_pulse), 32'(STEPS[i].e_race));
      if (STEPS[i].e_race)
        check(race_idx == STEPS[i].idx, "R5 step race_idx", 32'(race_idx), 32'(STEPS[i].idx));
      check(bcast_req == STEPS[i].e_bc, "R6 step bcast", 32'(bcast_req), 32'(STEPS[i].e_bc));
      if (STEPS[i].e_bc) begin
        check(bcast_vec == STEPS[i].e_bvec, "R6 step bcast_vec", 32'(bcast_vec), 32'(STEPS[i].e_bvec));
        check(bcast_idx == STEPS[i].idx, "R6 step bcast_idx", 32'(bcast_idx), 32'(STEPS[i].idx));
      end
    end

    // R5 pulse lasts a single cycle
    @(negedge clk); idle_inputs();
    tick();
    check(race_pulse == 0, "R5 pulse width", 32'(race_pulse), 0);
    check(bcast_req == 0, "R6 request width", 32'(bcast_req), 0);

    // R7 barrier with a same-cycle access
    @(negedge clk); idle_inputs();
    fill_valid = 1; fill_idx = 4'd2; fill_core = 2'd0;
    tick();
    @(negedge clk); idle_inputs();
    acc_valid = 1; acc_idx = 4'd2; acc_lockset = 16'h1111; acc_write = 1; acc_core = 2'd0;
    tick();
    check_line(4'd2, 2'b11, 16'h1111, "R3_R4 write narrows line 2");
    @(negedge clk); idle_inputs();
    barrier_exit = 1;
    acc_valid = 1; acc_idx = 4'd2; acc_lockset = 16'h0000; acc_write = 0; acc_core = 2'd1;
    tick();
    check_line(4'd2, 2'b11, 16'hFFFF, "R7 barrier drops access");
    check(race_pulse == 0, "R7 no race on barrier", 32'(race_pulse), 0);
    check_line(4'd5, 2'b10, 16'hFFFF, "R7 barrier resets other line");
    check_line(4'd9, 2'b00, 16'hFFFF, "R7 invalid line state kept");

    // R9 peer update empties line 2, later access stays silent
    @(negedge clk); idle_inputs();
    peer_valid = 1; peer_idx = 4'd2; peer_vec = 16'h0F0F;
    tick();
    check_line(4'd2, 2'b11, 16'h0F0F, "R9 peer overwrite");
    check(race_pulse == 0, "R9 no race from peer", 32'(race_pulse), 0);
    @(negedge clk); idle_inputs();
    acc_valid = 1; acc_idx = 4'd2; acc_lockset = 16'hFFFF; acc_write = 1; acc_core = 2'd0;
    tick();
    check(race_pulse == 0, "R5 already empty after peer", 32'(race_pulse), 0);
    check_line(4'd2, 2'b11, 16'h0F0F, "R3 vector kept");

    // R2 fill wins over access to same line
    @(negedge clk); idle_inputs();
    fill_valid = 1; fill_idx = 4'd7; fill_core = 2'd3;
    acc_valid = 1; acc_idx = 4'd7; acc_lockset = 16'h0000; acc_write = 1; acc_core = 2'd3;
    tick();
    check_line(4'd7, 2'b01, 16'hFFFF, "R2 fill beats access");
    check(race_pulse == 0, "R2 no race on clash", 32'(race_pulse), 0);

    @(negedge clk); idle_inputs();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule